// File: doc/BRIEF.md
# Serial ADC Host Command Controller

This block is the host side of a short serial exchange with an 8-bit, two-input sampling converter. A request carries an input selection: single-ended against ground or differential, and which input is positive. When the controller is idle it accepts the request and pulls the converter's select line low. It then sends a four-bit command on its data output, starting with a marker bit of one. The clock edges that follow give the converter its acquisition window and clock its conversion. The controller discards the two zero bits that lead the answer and assembles the eight result bits, most significant first.

The serial clock is a division of the system clock, set by a parameter. It idles low whenever the select line is high. After the last result bit the controller releases the select line and shows the byte with a one-cycle strobe. It keeps the select line high for at least one serial period before it starts another exchange.

Top module: `adc_link_ctrl`

## Requirements
- R1: During and straight after reset, `adc_cs_n` is 1, `adc_sclk` is 0, `adc_din` is 0, and `busy`, `res_valid` and `res_data` are 0.
- R2: A request seen while idle pulls `adc_cs_n` low on the next clock edge and raises `busy`. `busy` stays high until the controller can take a new request. A request made while busy starts no exchange and does not change the command in progress.
- R3: The command is four bits long, sent on `adc_din` in time order: 1 (start marker), the single-ended flag, the odd flag, then a dummy 0. The converter samples each bit on a rising `adc_sclk` edge.
- R4: `adc_din` changes only in the same cycle as a falling `adc_sclk` edge, or when an exchange begins. It never changes on a rising edge.
- R5: Each exchange has exactly 14 rising `adc_sclk` edges while `adc_cs_n` is low: 4 for the command, 2 for null bits, and 8 for result bits.
- R6: `adc_dout` is sampled on rising edges 7 to 14, and the bit from edge 7 becomes `res_data[7]`. The values on `adc_dout` at edges 1 to 6 do not affect the result.
- R7: `adc_sclk` is 0 whenever `adc_cs_n` is 1.
- R8: The `adc_sclk` period is SCLK_DIV system clocks, with SCLK_DIV/2 cycles high and SCLK_DIV/2 cycles low. SCLK_DIV is even and at least 2.
- R9: `res_valid` is a single-cycle pulse. It is asserted in the same cycle that `adc_cs_n` returns high. `res_data` holds the result until the next exchange completes.
- R10: Between two exchanges, `adc_cs_n` stays high for at least SCLK_DIV system clock cycles, even when `req_valid` is held high.
- R11: The select encoding follows the table below. Each combination of the two request fields must appear unchanged in the command.

| `req_single` | `req_odd` | Input selected |
|---|---|---|
| 1 | 0 | input 0 against ground |
| 1 | 1 | input 1 against ground |
| 0 | 0 | input 0 positive, input 1 negative |
| 0 | 1 | input 1 positive, input 0 negative |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start request, taken only when idle |
| req_single | input | 1 | 1: single-ended, 0: differential |
| req_odd | input | 1 | Input 1 selected (single-ended) or input 1 positive (differential) |
| busy | output | 1 | High from request acceptance until the controller is idle again |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_data | output | 8 | Last conversion result |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Command bit stream to the converter |
| adc_dout | input | 1 | Result bit stream from the converter |

## Verification
The converter model in the bench drives ones on its data line during the command, then zeros for the null bits, then the result. A controller that captured one edge early or late would show a shifted byte with a stray 1 or 0 at one end. The bench sends all four selection codes together with the all-zero and all-one result bytes. A swapped flag or an inverted bit would then appear in the command the model captures. A second request sent during an exchange, and a request held high across two exchanges, test that the controller neither restarts nor shortens the select-high gap. The bench also checks the length of the serial period and whether the data line moves on a rising edge. These catch a divider that counts wrongly and a serializer that updates on the wrong edge.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_GUARD = 2'd2
  } link_state_e;

  localparam int CMD_BITS  = 4;
  localparam int NULL_BITS = 2;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int SCLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = SCLK_DIV / 2;
  localparam int CW   = $clog2(HALF + 1);

  logic [CW-1:0] cnt;
  logic          phase_end;

  assign phase_end = (cnt == CW'(HALF - 1));
  assign rise_tick = run & phase_end & ~sclk;
  assign fall_tick = run & phase_end & sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (phase_end) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_cmd_ser.sv
module adc_cmd_ser #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         din
);
  logic [W-1:0] sr;

  assign din = sr[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (load) begin
      sr <= load_word;
    end else if (shift) begin
      sr <= {sr[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/adc_res_des.sv
module adc_res_des #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         cap,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word <= '0;
    end else if (cap) begin
      word <= {word[W-2:0], bit_in};
    end
  end
endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
  import adc_link_pkg::*;
#(
  parameter int SCLK_DIV = 4,
  parameter int RES_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_single,
  input  logic             req_odd,
  output logic             busy,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_din,
  input  logic             adc_dout
);
  localparam int TOTAL_EDGES = CMD_BITS + NULL_BITS + RES_W;
  localparam int FIRST_CAP   = CMD_BITS + NULL_BITS;
  localparam int EW          = $clog2(TOTAL_EDGES + 1);
  localparam int GW          = $clog2(SCLK_DIV + 1);

  link_state_e      state;
  logic [EW-1:0]    edge_cnt;
  logic [GW-1:0]    guard_cnt;
  logic             run;
  logic             rise_tick;
  logic             fall_tick;
  logic             start;
  logic             cap;
  logic             last_fall;
  logic [RES_W-1:0] shift_word;
  logic [CMD_BITS-1:0] cmd_word;

  assign run       = (state == ST_XFER);
  assign start     = (state == ST_IDLE) && req_valid;
  assign cap       = rise_tick && (edge_cnt >= EW'(FIRST_CAP));
  assign last_fall = fall_tick && (edge_cnt == EW'(TOTAL_EDGES));
  assign cmd_word  = {1'b1, req_single, req_odd, 1'b0};

  adc_sclk_gen #(.SCLK_DIV(SCLK_DIV)) u_clk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .sclk      (adc_sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  adc_cmd_ser #(.W(CMD_BITS)) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .load_word (cmd_word),
    .shift     (fall_tick),
    .din       (adc_din)
  );

  adc_res_des #(.W(RES_W)) u_res (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .cap    (cap),
    .bit_in (adc_dout),
    .word   (shift_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      adc_cs_n  <= 1'b1;
      busy      <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      edge_cnt  <= '0;
      guard_cnt <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            adc_cs_n <= 1'b0;
            busy     <= 1'b1;
            edge_cnt <= '0;
            state    <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (rise_tick) edge_cnt <= edge_cnt + 1'b1;
          if (last_fall) begin
            adc_cs_n  <= 1'b1;
            res_valid <= 1'b1;
            res_data  <= shift_word;
            guard_cnt <= '0;
            state     <= ST_GUARD;
          end
        end
        ST_GUARD: begin
          if (guard_cnt == GW'(SCLK_DIV - 1)) begin
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            guard_cnt <= guard_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_link_ctrl_chk.sv
module adc_link_ctrl_chk #(
  parameter int SCLK_DIV = 4,
  parameter int RES_W    = 8
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic res_valid,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic adc_din
);
  localparam int TOTAL = 6 + RES_W;
  localparam int GW    = $clog2(SCLK_DIV + 2);
  localparam int EW    = $clog2(TOTAL + 2);

  logic [GW-1:0] hi_cnt;
  logic [EW-1:0] rise_cnt;
  logic          sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= GW'(SCLK_DIV);
      rise_cnt <= '0;
      sclk_q   <= 1'b0;
    end else begin
      sclk_q <= adc_sclk;
      if (adc_cs_n) begin
        if (hi_cnt < GW'(SCLK_DIV)) hi_cnt <= hi_cnt + 1'b1;
        rise_cnt <= '0;
      end else begin
        hi_cnt <= '0;
        if (adc_sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  // R7
  p_idle_clk_low_r7: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> !adc_sclk);

  // R4
  p_din_stable_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_sclk) |-> $stable(adc_din));

  // R9
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R9
  p_valid_at_release_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cs_n) |-> res_valid);

  // R2
  p_busy_in_xfer_r2: assert property (@(posedge clk) disable iff (rst)
    !adc_cs_n |-> busy);

  // R10
  p_cs_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> (hi_cnt >= GW'(SCLK_DIV)));

  // R5
  p_edge_total_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cs_n) |-> (rise_cnt == EW'(TOTAL)));
endmodule

bind adc_link_ctrl adc_link_ctrl_chk #(.SCLK_DIV(SCLK_DIV), .RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .res_valid (res_valid),
  .adc_cs_n  (adc_cs_n),
  .adc_sclk  (adc_sclk),
  .adc_din   (adc_din)
);

// File: tb/adc_link_ctrl_test.sv
module adc_link_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SCLK_DIV   = 4;
  localparam int EDGES      = 14;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_single = 1'b0;
  logic       req_odd = 1'b0;
  logic       busy;
  logic       res_valid;
  logic [7:0] res_data;
  logic       adc_cs_n;
  logic       adc_sclk;
  logic       adc_din;
  logic       adc_dout = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_link_ctrl #(.SCLK_DIV(SCLK_DIV), .RES_W(8)) uut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_single (req_single),
    .req_odd    (req_odd),
    .busy       (busy),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .adc_cs_n   (adc_cs_n),
    .adc_sclk   (adc_sclk),
    .adc_din    (adc_din),
    .adc_dout   (adc_dout)
  );

  // Converter model: samples commands on rising edges, updates its output after them.
  logic [3:0] rx_cmd = '0;
  logic [7:0] model_data = '0;
  int  n_rise = 0;
  int  edges_seen = 0;
  int  xfers = 0;
  int  bad_period = 0;
  time last_rise = 0;

  always @(posedge adc_sclk or posedge adc_cs_n) begin
    if (adc_cs_n) begin
      if (n_rise > 0) begin
        edges_seen = n_rise;
        xfers = xfers + 1;
      end
      n_rise = 0;
      adc_dout <= 1'b1;
    end else begin
      n_rise = n_rise + 1;
      if (n_rise <= 4) rx_cmd[4 - n_rise] = adc_din;
      if (n_rise > 1 && ($time - last_rise) != SCLK_DIV * CLK_PERIOD)
        bad_period = bad_period + 1;
      last_rise = $time;
      if (n_rise == 4 || n_rise == 5) adc_dout <= 1'b0;
      else if (n_rise >= 6 && n_rise <= 13) adc_dout <= model_data[13 - n_rise];
      else adc_dout <= 1'b1;
    end
  end

  // Line monitors sampled away from the active edge
  int  din_bad = 0;
  int  idle_clk_bad = 0;
  logic prev_sclk = 1'b0;
  logic prev_din = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!prev_sclk && adc_sclk && (adc_din !== prev_din)) din_bad++;
      if (adc_cs_n && adc_sclk) idle_clk_bad++;
    end
    prev_sclk = adc_sclk;
    prev_din  = adc_din;
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_result(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (res_valid) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1", "cs_n in reset", int'(adc_cs_n), 1);
    check_eq("R1", "sclk in reset", int'(adc_sclk), 0);
    check_eq("R1", "din in reset", int'(adc_din), 0);
    check_eq("R1", "busy in reset", int'(busy), 0);
    check_eq("R1", "valid in reset", int'(res_valid), 0);
    check_eq("R1", "data in reset", int'(res_data), 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "cs_n after reset", int'(adc_cs_n), 1);
  endtask

  task automatic t_one_conversion(input logic sgl, input logic odd, input logic [7:0] data);
    bit seen;
    model_data = data;
    @(negedge clk);
    req_valid = 1'b1; req_single = sgl; req_odd = odd;
    @(negedge clk);
    req_valid = 1'b0;
    check_eq("R2", "cs_n low after request", int'(adc_cs_n), 0);
    check_eq("R2", "busy after request", int'(busy), 1);
    wait_result(seen);
    check_eq("R9", "result strobe seen", int'(seen), 1);
    check_eq("R9", "cs_n high with strobe", int'(adc_cs_n), 1);
    check_eq("R6", "result byte", int'(res_data), int'(data));
    check_eq("R3", "command word", int'(rx_cmd), int'({1'b1, sgl, odd, 1'b0}));
    check_eq("R11", "mux fields", int'(rx_cmd[2:1]), int'({sgl, odd}));
    check_eq("R5", "rising edges", edges_seen, EDGES);
    check_eq("R8", "serial period errors", bad_period, 0);
    @(negedge clk);
    check_eq("R9", "strobe one cycle", int'(res_valid), 0);
    check_eq("R9", "data held", int'(res_data), int'(data));
    while (busy) @(negedge clk);
  endtask

  task automatic t_mux_modes;
    t_one_conversion(1'b1, 1'b0, 8'hA5);
    t_one_conversion(1'b1, 1'b1, 8'h3C);
    t_one_conversion(1'b0, 1'b0, 8'h00);
    t_one_conversion(1'b0, 1'b1, 8'hFF);
    t_one_conversion(1'b1, 1'b0, 8'h81);
  endtask

  task automatic t_ignore_while_busy;
    bit seen;
    int x0;
    x0 = xfers;
    model_data = 8'h5A;
    @(negedge clk);
    req_valid = 1'b1; req_single = 1'b1; req_odd = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_single = 1'b0; req_odd = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    wait_result(seen);
    check_eq("R2", "first command kept", int'(rx_cmd), int'(4'b1110));
    check_eq("R2", "result of first", int'(res_data), 8'h5A);
    repeat (40) @(negedge clk);
    check_eq("R2", "no second exchange", xfers - x0, 1);
    check_eq("R2", "cs_n idle high", int'(adc_cs_n), 1);
    check_eq("R2", "busy back low", int'(busy), 0);
  endtask

  task automatic t_back_to_back;
    bit seen;
    int gap;
    model_data = 8'h96;
    @(negedge clk);
    req_valid = 1'b1; req_single = 1'b0; req_odd = 1'b1;
    wait_result(seen);
    check_eq("R10", "first result", int'(res_data), 8'h96);
    model_data = 8'h69;
    gap = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!adc_cs_n) break;
      gap++;
    end
    check_eq("R10", "cs high gap >= SCLK_DIV", int'(gap >= SCLK_DIV), 1);
    @(negedge clk);
    req_valid = 1'b0;
    wait_result(seen);
    check_eq("R10", "second result", int'(res_data), 8'h69);
    while (busy) @(negedge clk);
  endtask

  task automatic t_monitors;
    check_eq("R4", "din moved on rising edge", din_bad, 0);
    check_eq("R7", "sclk high while deselected", idle_clk_bad, 0);
  endtask

  initial begin
    t_reset();
    t_mux_modes();
    t_ignore_while_busy();
    t_back_to_back();
    t_monitors();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule